// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines into one processor interrupt. Each line is captured into a status word, either following the line level or latching a rising edge, depending on a per-line trigger mask fixed when the block is built. The status word is filtered by an enable word to give a pending word. The index of the lowest-numbered pending line is published as a vector, so the handler can branch without scanning bits.

Software sees eight 32-bit words on a simple word-addressed bus. The byte address is shifted right by two to select a word, and the two low address bits are ignored. Dedicated words acknowledge status bits and atomically set or clear enable bits, so no read-modify-write is needed. A control word holds two gates. One lets the processor interrupt out. The other lets the request lines change the status word at all.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Word index 0 holds status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector and 7 control. A write to index 0, 2 or 7 stores the written word. A read of 0, 2 or 7 returns the stored word. Reads of indices 3, 4 and 5 return zero. Byte address bits 1:0 are ignored.
- R2: The pending word always equals status AND enable.
- R3: The vector word holds the index of the lowest set bit of pending. It is 0xFFFFFFFF when pending is zero.
- R4: The interrupt output is high exactly when control bit 0 is set, control bit 1 is set and pending is nonzero. The output is combinational from the registers.
- R5: While control bit 1 is clear, changes on the request lines leave the status word unchanged.
- R6: While control bit 1 is set, the status bit of a level line takes the line value on every clock, whatever any write to acknowledge says in that cycle.
- R7: While control bit 1 is set, a rising edge on an edge line sets its status bit one clock later. The bit stays set after the line falls. A rising edge in the same cycle as an acknowledge of that bit leaves the bit set. Lines whose trigger-mask bit is 1 are edge lines; the default mask makes lines 31:16 edge lines and 15:0 level lines.
- R8: A write to acknowledge clears every status bit whose written bit is 1, unless R6 or R7 sets that bit in the same cycle.
- R9: A write to set-enable ORs the word into enable. A write to clear-enable clears the enable bits that are 1 in the word.
- R10: Writes to word indices 1, 6 and 8 or above change no register. Reads of index 8 or above return zero.
- R11: Reset clears status, enable and control. After reset the vector reads 0xFFFFFFFF and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| irq_in | input | NUM_SRC | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach is the same-cycle collision between a new rising edge on an edge line and an acknowledge of that same bit. The request line and the bus write must change on the same clock edge. The bench reaches it with a combined driver task that updates the request lines and issues the acknowledge in one bus cycle. Masked line changes while the hardware gate is closed are also checked. For these, the lines are toggled, both down and up, with the gate cleared, and the status word is read back afterwards.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned REG_COUNT = 8;
  localparam int unsigned IDX_W     = $clog2(REG_COUNT);
  localparam int unsigned VIDX_W    = $clog2(WORD_W);
  localparam int unsigned CTL_OUT_BIT = 0;
  localparam int unsigned CTL_HW_BIT  = 1;

  typedef enum logic [IDX_W-1:0] {
    OFS_STATUS = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_ENABLE = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETEN  = 3'd4,
    OFS_CLREN  = 3'd5,
    OFS_VECT   = 3'd6,
    OFS_CTRL   = 3'd7
  } vic_ofs_e;

  // Index of the lowest set bit, all ones when the word is empty.
  function automatic logic [WORD_W-1:0] lowest_index(input logic [WORD_W-1:0] bits);
    logic [WORD_W-1:0] idx;
    idx = '1;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (bits[i]) idx = WORD_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [WORD_W-1:0] clear_bits(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] msk);
    return cur & ~msk;
  endfunction
endpackage

// File: rtl/vic_regs.sv
`timescale 1ns/1ps
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] pending_word,
  input  logic [WORD_W-1:0] vector_word,
  output logic [WORD_W-1:0] enable_q,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              sts_wr,
  output logic              ack_wr,
  output logic [WORD_W-1:0] wr_word
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] word_idx;
  logic              in_map;
  logic              wr_hit;
  logic              wr_miss;
  vic_ofs_e          ofs;
  logic              addr_lsb_unused;

  assign word_idx        = bus_addr[ADDR_W-1:2];
  assign addr_lsb_unused = ^bus_addr[1:0];
  assign in_map          = (word_idx[WIDX_W-1:IDX_W] == '0);
  assign ofs             = vic_ofs_e'(word_idx[IDX_W-1:0]);
  assign wr_hit          = bus_sel && bus_wr && in_map;
  assign wr_miss         = bus_sel && bus_wr && !in_map;

  assign sts_wr  = wr_hit && (ofs == OFS_STATUS);
  assign ack_wr  = wr_hit && (ofs == OFS_ACK);
  assign wr_word = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_hit) begin
      case (ofs)
        OFS_ENABLE: enable_q <= bus_wdata;
        OFS_SETEN:  enable_q <= enable_q | bus_wdata;
        OFS_CLREN:  enable_q <= clear_bits(enable_q, bus_wdata);
        OFS_CTRL:   ctrl_q   <= bus_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && in_map) begin
      case (ofs)
        OFS_STATUS: bus_rdata = status_word;
        OFS_PEND:   bus_rdata = pending_word;
        OFS_ENABLE: bus_rdata = enable_q;
        OFS_VECT:   bus_rdata = vector_word;
        OFS_CTRL:   bus_rdata = ctrl_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  p_set_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ofs == OFS_SETEN) |=> ((enable_q & $past(bus_wdata)) == $past(bus_wdata)));
  p_clr_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ofs == OFS_CLREN) |=> ((enable_q & $past(bus_wdata)) == '0));
  p_out_of_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> ($stable(enable_q) && $stable(ctrl_q)));
  p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (ofs == OFS_PEND || ofs == OFS_VECT)) |=> ($stable(enable_q) && $stable(ctrl_q)));
endmodule

// File: rtl/vic_capture.sv
`timescale 1ns/1ps
module vic_capture
  import vic_pkg::*;
#(
  parameter int unsigned          NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0]   EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               hw_en,
  input  logic               sts_wr,
  input  logic               ack_wr,
  input  logic [WORD_W-1:0]  wr_word,
  output logic [NUM_SRC-1:0] status_q
);
  localparam logic [NUM_SRC-1:0] LVL_MASK = ~EDGE_MASK;

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise_edge;
  logic [NUM_SRC-1:0] status_nxt;
  logic [NUM_SRC-1:0] ack_bits;

  assign rise_edge = irq_in & ~prev_q;
  assign ack_bits  = ack_wr ? wr_word[NUM_SRC-1:0] : '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic base_b;
    assign base_b = (sts_wr ? wr_word[g] : status_q[g]) & ~ack_bits[g];
    if (EDGE_MASK[g]) begin : g_edge
      assign status_nxt[g] = base_b | (hw_en & rise_edge[g]);
    end else begin : g_level
      assign status_nxt[g] = hw_en ? irq_in[g] : base_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= irq_in;
      status_q <= status_nxt;
    end
  end

  p_hw_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en && !sts_wr && !ack_wr) |=> $stable(status_q));
  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |=> ((status_q & LVL_MASK) == ($past(irq_in) & LVL_MASK)));
  p_edge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |=> ((status_q & $past(rise_edge & EDGE_MASK)) == $past(rise_edge & EDGE_MASK)));
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !hw_en) |=> ((status_q & $past(wr_word[NUM_SRC-1:0])) == '0));
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
module vic_prio
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_SRC-1:0] enable_bits,
  input  logic               out_en,
  input  logic               hw_en,
  output logic [WORD_W-1:0]  pending_word,
  output logic [WORD_W-1:0]  vector_word,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] pending_src;
  logic [VIDX_W-1:0]  vec_idx;

  assign pending_src  = status_q & enable_bits;
  assign pending_word = WORD_W'(pending_src);
  assign vector_word  = lowest_index(pending_word);
  assign vec_idx      = vector_word[VIDX_W-1:0];
  assign irq_out      = out_en && hw_en && (pending_src != '0);

  p_vec_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_word != '0) |-> (pending_word[vec_idx] &&
      ((pending_word & ((WORD_W'(1) << vec_idx) - WORD_W'(1))) == '0)));
  p_vec_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_word == '0) |-> (vector_word == '1));
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);
  logic [WORD_W-1:0]  enable_q;
  logic [WORD_W-1:0]  ctrl_q;
  logic [WORD_W-1:0]  wr_word;
  logic [WORD_W-1:0]  pending_word;
  logic [WORD_W-1:0]  vector_word;
  logic [NUM_SRC-1:0] status_q;
  logic               sts_wr;
  logic               ack_wr;
  logic               hw_en;
  logic               out_en;

  assign hw_en  = ctrl_q[CTL_HW_BIT];
  assign out_en = ctrl_q[CTL_OUT_BIT];

  vic_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .status_word  (WORD_W'(status_q)),
    .pending_word (pending_word),
    .vector_word  (vector_word),
    .enable_q     (enable_q),
    .ctrl_q       (ctrl_q),
    .sts_wr       (sts_wr),
    .ack_wr       (ack_wr),
    .wr_word      (wr_word)
  );

  vic_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK[NUM_SRC-1:0])) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .hw_en    (hw_en),
    .sts_wr   (sts_wr),
    .ack_wr   (ack_wr),
    .wr_word  (wr_word),
    .status_q (status_q)
  );

  vic_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_q     (status_q),
    .enable_bits  (enable_q[NUM_SRC-1:0]),
    .out_en       (out_en),
    .hw_en        (hw_en),
    .pending_word (pending_word),
    .vector_word  (vector_word),
    .irq_out      (irq_out)
  );

  p_hw_gate_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |-> !irq_out);
  p_out_has_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vector_word != '1));
  p_pend_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_word & ~WORD_W'(status_q)) == '0) && ((pending_word & ~enable_q) == '0));
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NSRC-1:0] irq_in = '0;
  logic            irq_out;

  int unsigned n_cmp  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  bit          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW), .EDGE_MASK(32'hFFFF_0000)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // Monitor: pops what the driver expects and compares, 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    while (exp_q.size() != 0) begin
      automatic bit          k = kind_q.pop_front();
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string       t = tag_q.pop_front();
      automatic logic [31:0] a = k ? {31'd0, irq_out} : bus_rdata;
      n_cmp++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr_drv(input logic [AW-1:0] a, input logic [31:0] d, input logic [NSRC-1:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; irq_in = v;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    kind_q.push_back(1'b1); exp_q.push_back({31'd0, e}); tag_q.push_back(t);
  endtask

  task automatic drv(input logic [NSRC-1:0] v);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; irq_in = v;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(6'h00, 32'h0, "R11 status after reset");
    rd(6'h08, 32'h0, "R11 enable after reset");
    rd(6'h1C, 32'h0, "R11 control after reset");
    rd(6'h18, 32'hFFFF_FFFF, "R11 vector after reset");
    chk_irq(1'b0, "R11 output after reset");
    rd(6'h0C, 32'h0, "R1 acknowledge reads zero");
    rd(6'h10, 32'h0, "R1 set-enable reads zero");
    rd(6'h14, 32'h0, "R1 clear-enable reads zero");
    // R5 lines ignored while hardware gate closed
    drv(32'h0001_0003); idle();
    rd(6'h00, 32'h0, "R5 lines ignored");
    // R6 level capture once gate opens; held edge line gives no edge
    wr(6'h1C, 32'h3); idle();
    rd(6'h00, 32'h0000_0003, "R6 level capture");
    rd(6'h1C, 32'h3, "R1 control readback");
    rd(6'h04, 32'h0, "R2 pending zero with no enable");
    rd(6'h18, 32'hFFFF_FFFF, "R3 vector empty");
    chk_irq(1'b0, "R4 no pending");
    // R9 set-enable, R2, R3, R4
    wr(6'h10, 32'h2);
    rd(6'h08, 32'h2, "R9 set-enable");
    rd(6'h04, 32'h2, "R2 pending");
    rd(6'h18, 32'h1, "R3 vector one");
    chk_irq(1'b1, "R4 output high");
    wr(6'h10, 32'h0001_0001);
    rd(6'h08, 32'h0001_0003, "R9 set-enable OR");
    rd(6'h18, 32'h0, "R3 lowest wins");
    // R7 edge capture and stickiness
    drv(32'h0000_0003); drv(32'h0001_0003);
    rd(6'h00, 32'h0001_0003, "R7 rising edge");
    drv(32'h0000_0003); idle();
    rd(6'h00, 32'h0001_0003, "R7 edge sticky");
    drv(32'h0000_0001);
    rd(6'h00, 32'h0001_0001, "R6 level follows fall");
    // R8 acknowledge
    wr(6'h0C, 32'h0001_0000);
    rd(6'h00, 32'h0000_0001, "R8 ack edge bit");
    wr(6'h0C, 32'h0000_0001);
    rd(6'h00, 32'h0000_0001, "R6 level input beats ack");
    // R7 edge beats ack in the same cycle
    wr_drv(6'h0C, 32'h0001_0000, 32'h0001_0001);
    rd(6'h00, 32'h0001_0001, "R7 edge beats ack");
    // R9 clear-enable
    wr(6'h14, 32'h1);
    rd(6'h08, 32'h0001_0002, "R9 clear-enable");
    rd(6'h04, 32'h0001_0000, "R2 pending after clear");
    rd(6'h18, 32'd16, "R3 vector sixteen");
    chk_irq(1'b1, "R4 output high again");
    // R4 control gates
    wr(6'h1C, 32'h2);
    chk_irq(1'b0, "R4 output bit clear");
    rd(6'h04, 32'h0001_0000, "R2 pending kept");
    wr(6'h1C, 32'h1);
    chk_irq(1'b0, "R4 hardware bit clear");
    drv(32'h0); drv(32'h0002_0000); idle();
    rd(6'h00, 32'h0001_0001, "R5 lines ignored");
    wr(6'h0C, 32'h1);
    rd(6'h00, 32'h0001_0000, "R8 ack with gate closed");
    // R1 direct status write
    wr(6'h00, 32'h0000_0F00);
    rd(6'h00, 32'h0000_0F00, "R1 status write");
    rd(6'h04, 32'h0, "R2 pending none");
    rd(6'h18, 32'hFFFF_FFFF, "R3 vector empty");
    // R10 ignored writes
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, 32'h0, "R10 pending write ignored");
    wr(6'h18, 32'h5);
    rd(6'h18, 32'hFFFF_FFFF, "R10 vector write ignored");
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, 32'h0, "R10 out-of-map read");
    rd(6'h08, 32'h0001_0002, "R10 enable kept");
    rd(6'h00, 32'h0000_0F00, "R10 status kept");
    rd(6'h1C, 32'h1, "R10 control kept");
    rd(6'h3C, 32'h0, "R10 high index read");
    // R1 direct enable write, R3, R4
    wr(6'h08, 32'h0000_0100);
    rd(6'h08, 32'h0000_0100, "R1 enable write");
    rd(6'h18, 32'd8, "R3 vector eight");
    chk_irq(1'b0, "R4 hardware bit clear");
    drv(32'h0000_0100);
    wr(6'h1C, 32'h3); idle();
    rd(6'h00, 32'h0000_0100, "R6 level refresh");
    rd(6'h1F, 32'h3, "R1 low address bits ignored");
    rd(6'h18, 32'd8, "R3 vector eight");
    chk_irq(1'b1, "R4 both bits set");
    // R11 reset mid-run
    @(negedge clk);
    bus_sel = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(6'h00, 32'h0, "R11 status cleared");
    rd(6'h1C, 32'h0, "R11 control cleared");
    rd(6'h08, 32'h0, "R11 enable cleared");
    chk_irq(1'b0, "R11 output low");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule